// File: doc/BRIEF.md
# Serial Flash Bit Front End with Hold Pause

This block is the slave-side bit engine of a serial flash interface. It watches the serial clock, chip select, hold and serial input pins, all taken into the local `clk` domain, and finds serial-clock edges by comparing the current level with the one registered on the previous cycle. On each rising serial-clock edge it samples one data bit, most significant bit first. Every eighth sampled bit it delivers a complete byte to the command decoder with a one-cycle strobe. On each falling serial-clock edge it shifts out the next bit of a byte that the decoder has loaded.

The active-low hold pin pauses serial traffic without ending the transaction. A hold can only start or end while the serial clock is low. If the hold pin changes while the clock is high, the change waits until the clock next goes low. While the pause is in force, serial-clock edges are ignored, the bit position and both shift registers keep their values, and the output driver is released. Hold is ignored while chip select is high or while the quad-enable input marks the pin as a data lane. The pause never affects internal program, erase or register-write activity.

Top module: `serial_hold_front`

## Requirements
- R1: After reset, `rx_valid`, `hold_active`, `so_oe` and `busy_out` are 0.
- R2: With chip select low and no hold, `si` is sampled at each rising `sclk` edge, most significant bit first. After the eighth sample, `rx_byte` holds the byte and `rx_valid` is high for exactly one `clk` cycle.
- R3: A `tx_load` pulse with chip select low captures `tx_byte` and enables `so_oe`. Each later falling `sclk` edge puts the next bit on `so`, most significant bit first.
- R4: With chip select low and `sclk` low, `hold_n` going low sets `hold_active` on the next `clk` edge.
- R5: If `hold_n` goes low while `sclk` is high, `hold_active` stays 0 until `sclk` is seen low.
- R6: If `hold_n` goes high while `sclk` is high, `hold_active` stays 1 until `sclk` is seen low.
- R7: While `hold_active` is 1, `so_oe` is 0 and `sclk` edges change neither the bit position, nor the received data, nor the transmit bits. Reception continues correctly after the hold ends.
- R8: While `cs_n` is high, `hold_n` has no effect and `hold_active` is 0. Raising `cs_n` clears a partly received byte, so the next byte starts at bit 7.
- R9: While `quad_en` is 1, `hold_n` has no effect, `hold_active` stays 0 and bits keep being sampled.
- R10: `busy_out` follows `busy` one `clk` cycle later, whether a hold is active or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sclk | input | 1 | Serial clock level |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Hold request, active low |
| si | input | 1 | Serial data in |
| quad_en | input | 1 | 1 = hold pin used as a data lane, hold disabled |
| busy | input | 1 | Internal operation in progress |
| tx_load | input | 1 | Load strobe for the transmit byte |
| tx_byte | input | DATA_W | Byte to shift out |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so` |
| rx_valid | output | 1 | One-cycle strobe when a byte is complete |
| rx_byte | output | DATA_W | Last complete received byte |
| hold_active | output | 1 | Hold pause in force |
| busy_out | output | 1 | Registered internal busy, never gated by hold |

## Verification
The embedded properties check, on every cycle, the rules that involve only one or two cycles. Hold state never changes while the serial clock is high. Chip select and quad enable always clear the hold. A pause freezes the bit position and the transmit state. Valid strobes last one cycle, and `busy_out` tracks `busy`. Other behaviour can only be shown by the directed scenarios, because it depends on the whole transaction. These include the bit order of a full received and transmitted byte, a correct byte assembled across a pause, a deferred hold entry and exit with the clock high, and a counter reset by chip select.

// File: rtl/serial_hold_front.sv
module serial_hold_front #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  input  logic              quad_en,
  input  logic              busy,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              so,
  output logic              so_oe,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              hold_active,
  output logic              busy_out
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic              so_r;
  logic              armed;

  wire sck_rise = sclk & ~sclk_d;
  wire sck_fall = ~sclk & sclk_d;
  wire live     = ~cs_n & ~hold_active;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              hold_active <= 1'b0;
    else if (cs_n | quad_en) hold_active <= 1'b0;
    else if (!sclk)          hold_active <= ~hold_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (live && sck_rise) begin
        if (bit_cnt == LAST) begin
          rx_byte  <= {rx_sh, si};
          rx_valid <= 1'b1;
          bit_cnt  <= '0;
        end else begin
          rx_sh   <= {rx_sh[DATA_W-3:0], si};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh <= '0;
      so_r  <= 1'b0;
    end else if (tx_load) begin
      tx_sh <= tx_byte;
    end else if (live && sck_fall) begin
      so_r  <= tx_sh[DATA_W-1];
      tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (cs_n)    armed <= 1'b0;
    else if (tx_load) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_out <= 1'b0;
    else        busy_out <= busy;
  end

  assign so    = so_r;
  assign so_oe = ~cs_n & ~hold_active & armed;

  p_cs_clears_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !hold_active);

  p_quad_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quad_en |=> !hold_active);

  p_hold_waits_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !quad_en && sclk) |=> $stable(hold_active));

  p_hold_freeze_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !cs_n) |=> ($stable(bit_cnt) && $stable(rx_byte)));

  p_hold_freeze_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !tx_load) |=> ($stable(tx_sh) && $stable(so_r)));

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_busy_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_out) |-> $past(busy));
endmodule

// File: tb/serial_hold_front_bench.sv
module serial_hold_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic quad_en = 1'b0, busy = 1'b0, tx_load = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic so, so_oe, rx_valid, hold_active, busy_out;
  logic [7:0] rx_byte;
  int total = 0, bad = 0, rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #5 clk = ~clk;

  serial_hold_front #(.DATA_W(8)) u_serial_hold_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n),
    .si(si), .quad_en(quad_en), .busy(busy), .tx_load(tx_load),
    .tx_byte(tx_byte), .so(so), .so_oe(so_oe), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .hold_active(hold_active), .busy_out(busy_out));

  always @(negedge clk) if (rx_valid) begin
    rx_cnt  = rx_cnt + 1;
    rx_last = rx_byte;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic v);
    si = v; sclk = 1'b1; wt(2);
    sclk = 1'b0; wt(2);
  endtask

  task automatic sbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
  endtask

  task automatic end_frame();
    cs_n = 1'b1; hold_n = 1'b1; wt(3);
  endtask

  task automatic t_reset();
    chk(rx_valid, 0, "R1 rx_valid");
    chk(hold_active, 0, "R1 hold_active");
    chk(so_oe, 0, "R1 so_oe");
    chk(busy_out, 0, "R1 busy_out");
  endtask

  task automatic t_rx();
    int c0;
    cs_n = 1'b0; wt(2);
    c0 = rx_cnt;
    sbyte(8'hA5);
    chk(rx_cnt - c0, 1, "R2 one strobe");
    chk(rx_last, 8'hA5, "R2 byte A5");
    c0 = rx_cnt;
    sbyte(8'h3C);
    chk(rx_cnt - c0, 1, "R2 one strobe second");
    chk(rx_last, 8'h3C, "R2 byte 3C");
    end_frame();
  endtask

  task automatic t_tx();
    logic [7:0] pat = 8'hC6;
    int errs = 0;
    cs_n = 1'b0; wt(1);
    tx_byte = pat; tx_load = 1'b1; wt(1); tx_load = 1'b0; wt(1);
    chk(so_oe, 1, "R3 so_oe after load");
    for (int i = 7; i >= 0; i--) begin
      sbit(1'b0);
      if (so !== pat[i]) errs++;
    end
    chk(errs, 0, "R3 so bit order");
    end_frame();
    chk(so_oe, 0, "R3 so_oe off after cs high");
  endtask

  task automatic t_hold_mid();
    int c0;
    logic so_hold;
    cs_n = 1'b0; wt(1);
    tx_byte = 8'hAA; tx_load = 1'b1; wt(1); tx_load = 1'b0; wt(1);
    c0 = rx_cnt;
    sbit(1); sbit(1); sbit(0);
    hold_n = 1'b0; wt(1);
    chk(hold_active, 1, "R4 hold entry sclk low");
    chk(so_oe, 0, "R7 so_oe off in hold");
    so_hold = so;
    for (int i = 0; i < 6; i++) sbit(1'b1);
    chk(so, so_hold, "R7 so frozen");
    chk(rx_cnt - c0, 0, "R7 no strobe in hold");
    hold_n = 1'b1; wt(2);
    chk(hold_active, 0, "R7 hold exit");
    chk(so_oe, 1, "R7 so_oe back");
    sbit(1); sbit(0); sbit(0); sbit(1); sbit(0);
    chk(rx_cnt - c0, 1, "R7 one strobe after hold");
    chk(rx_last, 8'b1101_0010, "R7 byte across hold");
    end_frame();
  endtask

  task automatic t_hold_deferred();
    int c0;
    cs_n = 1'b0; wt(2);
    c0 = rx_cnt;
    si = 1'b1; sclk = 1'b1; wt(1);
    hold_n = 1'b0; wt(3);
    chk(hold_active, 0, "R5 entry deferred");
    sclk = 1'b0; wt(2);
    chk(hold_active, 1, "R5 entry at sclk low");
    si = 1'b0; sclk = 1'b1; wt(1);
    hold_n = 1'b1; wt(3);
    chk(hold_active, 1, "R6 exit deferred");
    sclk = 1'b0; wt(2);
    chk(hold_active, 0, "R6 exit at sclk low");
    sbyte_tail7(7'b0110100);
    chk(rx_cnt - c0, 1, "R6 one strobe");
    chk(rx_last, 8'hB4, "R6 byte B4");
    end_frame();
  endtask

  task automatic sbyte_tail7(input logic [6:0] b);
    for (int i = 6; i >= 0; i--) sbit(b[i]);
  endtask

  task automatic t_cs();
    cs_n = 1'b1; hold_n = 1'b0; wt(3);
    chk(hold_active, 0, "R8 hold ignored cs high");
    hold_n = 1'b1; cs_n = 1'b0; wt(2);
    sbit(1); sbit(1); sbit(1);
    cs_n = 1'b1; wt(2); cs_n = 1'b0; wt(2);
    sbyte(8'h5A);
    chk(rx_last, 8'h5A, "R8 counter reset by cs");
    end_frame();
  endtask

  task automatic t_quad();
    int c0;
    quad_en = 1'b1; cs_n = 1'b0; wt(2);
    hold_n = 1'b0; wt(3);
    chk(hold_active, 0, "R9 hold off in quad");
    c0 = rx_cnt;
    sbyte(8'h81);
    chk(rx_cnt - c0, 1, "R9 bits sampled");
    chk(rx_last, 8'h81, "R9 byte 81");
    end_frame();
    quad_en = 1'b0;
  endtask

  task automatic t_busy();
    cs_n = 1'b0; wt(2);
    hold_n = 1'b0; busy = 1'b1; wt(2);
    chk(hold_active, 1, "R10 hold set");
    chk(busy_out, 1, "R10 busy kept in hold");
    busy = 1'b0; wt(2);
    chk(busy_out, 0, "R10 busy drop in hold");
    end_frame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wt(3); rst_n = 1'b1; wt(2);
    t_reset();
    t_rx();
    t_tx();
    t_hold_mid();
    t_hold_deferred();
    t_cs();
    t_quad();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule